// File: doc/BRIEF.md
# Paired Floating-Point Register Renamer

This block sits at the dispatch stage. It renames the floating-point register operands of up to two instructions in each clock cycle. This happens before the instructions are routed to their execution units. Loads and other operations headed for the fixed-point side can also write a floating-point register, so every instruction stream goes through the one shared map. Each slot of the pair carries three architectural source registers, which is enough for a fused multiply-add, and an optional architectural destination.

Source lookups are combinational and appear in the same cycle as the request. Slot 0 therefore needs three source reads and one old-destination read, and slot 1 needs the same four, for eight table reads per cycle. A destination takes a fresh physical tag from a free pool. Slot 1 always sees the result of any rename that slot 0 performs in the same cycle. The pair is accepted as a whole or not at all: `rdy` drops when the pool cannot cover every destination in the pair.

Retirement hands back the superseded physical tags through a two-wide commit input. Register data, execution and recovery after a wrong prediction are handled elsewhere.

Top module: `fp_rename_pair`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, and the free pool holds tags 32 to 39. These are handed out in ascending order.
- R2: For every valid slot, `src_tag` returns the current map entry of each of its three sources in the same cycle. Slot s, source k uses bits [(3s+k)*5 +: 5] of `req_src` and bits [(3s+k)*6 +: 6] of `src_tag`.
- R3: A slot allocates when its `req_valid` and `req_dst_en` bits are both 1. Slot 0 receives the oldest free tag. Slot 1 receives the next oldest, or the oldest when slot 0 does not allocate. `dst_tag` gives the new tag and `old_tag` gives the tag the destination mapped to before the rename.
- R4: When slot 0 allocates and a source of slot 1 names slot 0's destination, that source gets slot 0's new tag. Slot 1's `old_tag` follows the same rule.
- R5: When both slots allocate the same architectural register, the map then holds slot 1's tag.
- R6: `rdy` is 1 exactly when the number of free tags is at least the number of allocating slots. A pair that writes no destination is accepted even when the pool is empty.
- R7: When `rdy` is 0, neither the map nor the free pool changes. Returned tags are still accepted during such a cycle.
- R8: Each `cmt_valid` bit returns one tag to the pool. Slot 0's tag is queued ahead of slot 1's. A returned tag can be allocated from the next cycle on, not in the cycle it is returned.
- R9: An accepted rename is visible to lookups from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Slot valid, bit s for slot s |
| req_dst_en | input | 2 | Slot writes a destination |
| req_src | input | 30 | Three 5-bit architectural sources per slot |
| req_dst | input | 10 | 5-bit architectural destination per slot |
| rdy | output | 1 | Pair accepted this cycle |
| src_tag | output | 36 | Physical tag for each source |
| dst_tag | output | 12 | Newly allocated tag per slot |
| old_tag | output | 12 | Previous mapping of each destination |
| cmt_valid | input | 2 | Tag return strobe per lane |
| cmt_tag | input | 12 | Tag returned per lane |

## Verification
All outputs (`rdy`, `src_tag`, `dst_tag`, `old_tag`) are combinational. They are due in the same cycle as the request, so the bench drives on the falling edge and compares 1 ns later, before the next rising edge. Map and pool updates, including returned tags, take effect at that rising edge. They are therefore checked through a lookup or an allocation in the next cycle, never in the cycle that caused them. The same rule applies to rejected pairs: state that could have been touched is read back one cycle later.

// File: rtl/fprn_pkg.sv
package fprn_pkg;

  // pointer advance with wrap on a non-power-of-two ring
  function automatic int unsigned wrap_add(input int unsigned ptr,
                                           input int unsigned step,
                                           input int unsigned depth);
    return (ptr + step) % depth;
  endfunction

  // number of slots that need a fresh tag
  function automatic logic [1:0] alloc_count(input logic [1:0] valid,
                                             input logic [1:0] dst_en);
    logic [1:0] a;
    a = valid & dst_en;
    return {1'b0, a[0]} + {1'b0, a[1]};
  endfunction

endpackage

// File: rtl/fprn_map_table.sv
module fprn_map_table #(
  parameter int unsigned AW    = 5,
  parameter int unsigned PW    = 6,
  parameter int unsigned NARCH = 32,
  parameter int unsigned NRD   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][PW-1:0]   rd_tag,
  input  logic                     we0,
  input  logic [AW-1:0]            wa0,
  input  logic [PW-1:0]            wd0,
  input  logic                     we1,
  input  logic [AW-1:0]            wa1,
  input  logic [PW-1:0]            wd1
);

  logic [PW-1:0] map_q [NARCH];

  always_ff @(posedge clk) begin
    for (int e = 0; e < int'(NARCH); e++) begin
      if (!rst_n)
        map_q[e] <= PW'(e);
      else if (we1 && wa1 == AW'(e))
        map_q[e] <= wd1;
      else if (we0 && wa0 == AW'(e))
        map_q[e] <= wd0;
    end
  end

  for (genvar r = 0; r < int'(NRD); r++) begin : g_rd
    assign rd_tag[r] = map_q[rd_addr[r]];
  end

  AST_MAP_LAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    we1 |=> map_q[$past(wa1)] == $past(wd1)); // R5

endmodule

// File: rtl/fprn_free_list.sv
module fprn_free_list
  import fprn_pkg::*;
#(
  parameter int unsigned PW    = 6,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BASE  = 32,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pop_n,
  input  logic [1:0]    push_en,
  input  logic [PW-1:0] push_tag0,
  input  logic [PW-1:0] push_tag1,
  output logic [PW-1:0] head0,
  output logic [PW-1:0] head1,
  output logic [CW-1:0] count
);

  logic [PW-1:0] ring [DEPTH];
  logic [IW-1:0] rd_ptr, wr_ptr, rd_ptr1, wr_ptr1;
  logic [1:0]    push_n;
  logic [CW:0]   cnt_next;

  assign rd_ptr1  = IW'(wrap_add(32'(rd_ptr), 32'd1, DEPTH));
  assign wr_ptr1  = IW'(wrap_add(32'(wr_ptr), 32'd1, DEPTH));
  assign head0    = ring[rd_ptr];
  assign head1    = ring[rd_ptr1];
  assign push_n   = {1'b0, push_en[0]} + {1'b0, push_en[1]};
  assign cnt_next = {1'b0, count} + (CW+1)'(push_n) - (CW+1)'(pop_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) ring[i] <= PW'(BASE + i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CW'(DEPTH);
    end else begin
      if (push_en[0]) ring[wr_ptr] <= push_tag0;
      if (push_en[1]) ring[push_en[0] ? wr_ptr1 : wr_ptr] <= push_tag1;
      rd_ptr <= IW'(wrap_add(32'(rd_ptr), 32'(pop_n), DEPTH));
      wr_ptr <= IW'(wrap_add(32'(wr_ptr), 32'(push_n), DEPTH));
      count  <= cnt_next[CW-1:0];
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_next <= (CW+1)'(DEPTH)); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n == 2'd0 && push_en == 2'b00) |=> ($stable(count) && $stable(rd_ptr))); // R7

endmodule

// File: rtl/fprn_pair_link.sv
module fprn_pair_link #(
  parameter int unsigned AW   = 5,
  parameter int unsigned PW   = 6,
  parameter int unsigned NSRC = 3
) (
  input  logic                    lead_live,
  input  logic [AW-1:0]           lead_arch,
  input  logic [PW-1:0]           lead_new,
  input  logic [NSRC:0][AW-1:0]   trail_arch,
  input  logic [NSRC:0][PW-1:0]   trail_raw,
  output logic [NSRC:0][PW-1:0]   trail_tag
);

  // same-cycle producer overrides the table entry
  function automatic logic [PW-1:0] forward(input logic          live,
                                            input logic [AW-1:0] prod_arch,
                                            input logic [PW-1:0] prod_tag,
                                            input logic [AW-1:0] cons_arch,
                                            input logic [PW-1:0] table_tag);
    return (live && prod_arch == cons_arch) ? prod_tag : table_tag;
  endfunction

  for (genvar i = 0; i <= int'(NSRC); i++) begin : g_fwd
    assign trail_tag[i] = forward(lead_live, lead_arch, lead_new,
                                  trail_arch[i], trail_raw[i]);
  end

endmodule

// File: rtl/fp_rename_pair.sv
module fp_rename_pair
  import fprn_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 40,
  parameter int unsigned NSRC     = 3,
  localparam int unsigned AW      = $clog2(NUM_ARCH),
  localparam int unsigned PW      = $clog2(NUM_PHYS),
  localparam int unsigned FREE_N  = NUM_PHYS - NUM_ARCH,
  localparam int unsigned CW      = $clog2(FREE_N + 1),
  localparam int unsigned NRD     = 2 * (NSRC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             req_valid,
  input  logic [1:0]             req_dst_en,
  input  logic [2*NSRC*AW-1:0]   req_src,
  input  logic [2*AW-1:0]        req_dst,
  output logic                   rdy,
  output logic [2*NSRC*PW-1:0]   src_tag,
  output logic [2*PW-1:0]        dst_tag,
  output logic [2*PW-1:0]        old_tag,
  input  logic [1:0]             cmt_valid,
  input  logic [2*PW-1:0]        cmt_tag
);

  logic [1:0]                alloc;
  logic [1:0]                need;
  logic [1:0]                pop_n;
  logic [CW-1:0]             free_cnt;
  logic [PW-1:0]             head0, head1, new0, new1;
  logic [NRD-1:0][AW-1:0]    rd_addr;
  logic [NRD-1:0][PW-1:0]    rd_tag;
  logic [NSRC:0][AW-1:0]     trail_arch;
  logic [NSRC:0][PW-1:0]     trail_raw, trail_tag;
  logic                      take0, take1;

  // slot s, source k -> read port s*(NSRC+1)+k ; port s*(NSRC+1)+NSRC is old dst
  for (genvar s = 0; s < 2; s++) begin : g_slot
    for (genvar k = 0; k < int'(NSRC); k++) begin : g_src
      assign rd_addr[s*(NSRC+1)+k] = req_src[(s*NSRC+k)*AW +: AW];
    end
    assign rd_addr[s*(NSRC+1)+NSRC] = req_dst[s*AW +: AW];
  end

  assign alloc = req_valid & req_dst_en;
  assign need  = alloc_count(req_valid, req_dst_en);
  assign rdy   = ({1'b0, free_cnt} >= (CW+1)'(need));
  assign pop_n = rdy ? need : 2'd0;
  assign take0 = rdy & alloc[0];
  assign take1 = rdy & alloc[1];
  assign new0  = head0;
  assign new1  = alloc[0] ? head1 : head0;

  fprn_map_table #(.AW(AW), .PW(PW), .NARCH(NUM_ARCH), .NRD(NRD)) i_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(rd_addr),
    .rd_tag (rd_tag),
    .we0    (take0),
    .wa0    (req_dst[0 +: AW]),
    .wd0    (new0),
    .we1    (take1),
    .wa1    (req_dst[AW +: AW]),
    .wd1    (new1)
  );

  fprn_free_list #(.PW(PW), .DEPTH(FREE_N), .BASE(NUM_ARCH)) i_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_n    (pop_n),
    .push_en  (cmt_valid),
    .push_tag0(cmt_tag[0 +: PW]),
    .push_tag1(cmt_tag[PW +: PW]),
    .head0    (head0),
    .head1    (head1),
    .count    (free_cnt)
  );

  for (genvar i = 0; i <= int'(NSRC); i++) begin : g_trail
    assign trail_arch[i] = rd_addr[(NSRC+1)+i];
    assign trail_raw[i]  = rd_tag[(NSRC+1)+i];
  end

  fprn_pair_link #(.AW(AW), .PW(PW), .NSRC(NSRC)) i_link (
    .lead_live (alloc[0]),
    .lead_arch (req_dst[0 +: AW]),
    .lead_new  (new0),
    .trail_arch(trail_arch),
    .trail_raw (trail_raw),
    .trail_tag (trail_tag)
  );

  for (genvar k = 0; k < int'(NSRC); k++) begin : g_out
    assign src_tag[k*PW +: PW]        = rd_tag[k];
    assign src_tag[(NSRC+k)*PW +: PW] = trail_tag[k];
  end
  assign dst_tag = {new1, new0};
  assign old_tag = {trail_tag[NSRC], rd_tag[NSRC]};

  AST_DISTINCT_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && alloc == 2'b11) |-> (new0 != new1)); // R3
  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && cmt_valid == 2'b00) |=> $stable(free_cnt)); // R7

endmodule

// File: tb/test_fp_rename_pair.sv
`timescale 1ns/1ps
module test_fp_rename_pair;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  req_valid, req_dst_en, cmt_valid;
  logic [29:0] req_src;
  logic [9:0]  req_dst;
  logic        rdy;
  logic [35:0] src_tag;
  logic [11:0] dst_tag, old_tag, cmt_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_rename_pair i_fp_rename_pair (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst_en(req_dst_en),
    .req_src(req_src), .req_dst(req_dst), .rdy(rdy), .src_tag(src_tag),
    .dst_tag(dst_tag), .old_tag(old_tag), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag)
  );

  typedef struct packed {
    logic [1:0] v;  logic [1:0] e;
    logic [4:0] s0a; logic [4:0] s0b; logic [4:0] s0c; logic [4:0] d0;
    logic [4:0] s1a; logic [4:0] s1b; logic [4:0] s1c; logic [4:0] d1;
    logic       rdy;
    logic [5:0] t0a; logic [5:0] t0b; logic [5:0] t0c; logic [5:0] n0; logic [5:0] o0;
    logic [5:0] t1a; logic [5:0] t1b; logic [5:0] t1c; logic [5:0] n1; logic [5:0] o1;
  } vec_t;

  // stimulus and expected tags, applied in order from reset
  localparam vec_t VEC [7] = '{
    '{2'd3, 2'd3, 5'd1, 5'd2, 5'd3, 5'd4, 5'd4, 5'd5, 5'd6, 5'd7, 1'b1,
      6'd1, 6'd2, 6'd3, 6'd32, 6'd4, 6'd32, 6'd5, 6'd6, 6'd33, 6'd7},
    '{2'd3, 2'd1, 5'd4, 5'd7, 5'd0, 5'd9, 5'd9, 5'd9, 5'd4, 5'd0, 1'b1,
      6'd32, 6'd33, 6'd0, 6'd34, 6'd9, 6'd34, 6'd34, 6'd32, 6'd0, 6'd0},
    '{2'd3, 2'd3, 5'd10, 5'd1, 5'd1, 5'd10, 5'd10, 5'd2, 5'd2, 5'd10, 1'b1,
      6'd10, 6'd1, 6'd1, 6'd35, 6'd10, 6'd35, 6'd2, 6'd2, 6'd36, 6'd35},
    '{2'd1, 2'd1, 5'd10, 5'd4, 5'd9, 5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1,
      6'd36, 6'd32, 6'd34, 6'd37, 6'd11, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
    '{2'd3, 2'd3, 5'd11, 5'd0, 5'd0, 5'd12, 5'd12, 5'd11, 5'd0, 5'd13, 1'b1,
      6'd37, 6'd0, 6'd0, 6'd38, 6'd12, 6'd38, 6'd37, 6'd0, 6'd39, 6'd13},
    '{2'd1, 2'd1, 5'd13, 5'd0, 5'd0, 5'd14, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0,
      6'd39, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
    '{2'd3, 2'd0, 5'd13, 5'd12, 5'd10, 5'd0, 5'd4, 5'd11, 5'd9, 5'd0, 1'b1,
      6'd39, 6'd38, 6'd36, 6'd0, 6'd0, 6'd32, 6'd37, 6'd34, 6'd0, 6'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int st(input int s, input int k);
    return int'(src_tag[(s*3+k)*6 +: 6]);
  endfunction

  task automatic apply(input logic [1:0] v, input logic [1:0] e,
                       input int s0a, input int s0b, input int s0c, input int d0,
                       input int s1a, input int s1b, input int s1c, input int d1,
                       input logic [1:0] cv, input int c0, input int c1);
    @(negedge clk);
    req_valid  = v;
    req_dst_en = e;
    req_src    = {5'(s1c), 5'(s1b), 5'(s1a), 5'(s0c), 5'(s0b), 5'(s0a)};
    req_dst    = {5'(d1), 5'(d0)};
    cmt_valid  = cv;
    cmt_tag    = {6'(c1), 6'(c0)};
    #1;
  endtask

  task automatic idle();
    apply(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_dst_en = '0; req_src = '0; req_dst = '0;
    cmt_valid = '0; cmt_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity mapping after reset, lookup only
    apply(2'b01, 2'b00, 31, 0, 17, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    chk("R1", "rdy idle", int'(rdy), 1);
    chk("R1", "src31", st(0, 0), 31);
    chk("R1", "src17", st(0, 2), 17);

    // table walk covering R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 7; i++) begin
      apply(VEC[i].v, VEC[i].e, VEC[i].s0a, VEC[i].s0b, VEC[i].s0c, VEC[i].d0,
            VEC[i].s1a, VEC[i].s1b, VEC[i].s1c, VEC[i].d1, 2'b00, 0, 0);
      chk("R6", $sformatf("vec%0d rdy", i), int'(rdy), int'(VEC[i].rdy));
      chk("R2", $sformatf("vec%0d s0a", i), st(0, 0), int'(VEC[i].t0a));
      chk("R2", $sformatf("vec%0d s0b", i), st(0, 1), int'(VEC[i].t0b));
      chk("R2", $sformatf("vec%0d s0c", i), st(0, 2), int'(VEC[i].t0c));
      if (VEC[i].v[1]) begin
        chk("R4", $sformatf("vec%0d s1a", i), st(1, 0), int'(VEC[i].t1a));
        chk("R4", $sformatf("vec%0d s1b", i), st(1, 1), int'(VEC[i].t1b));
        chk("R4", $sformatf("vec%0d s1c", i), st(1, 2), int'(VEC[i].t1c));
      end
      if (VEC[i].rdy && VEC[i].v[0] && VEC[i].e[0]) begin
        chk("R3", $sformatf("vec%0d new0", i), int'(dst_tag[5:0]), int'(VEC[i].n0));
        chk("R3", $sformatf("vec%0d old0", i), int'(old_tag[5:0]), int'(VEC[i].o0));
      end
      if (VEC[i].rdy && VEC[i].v[1] && VEC[i].e[1]) begin
        chk("R3", $sformatf("vec%0d new1", i), int'(dst_tag[11:6]), int'(VEC[i].n1));
        chk("R5", $sformatf("vec%0d old1", i), int'(old_tag[11:6]), int'(VEC[i].o1));
      end
    end

    // R7: rejected rename of arch 14 left the map unchanged; R5: arch 10 holds slot 1 tag
    apply(2'b01, 2'b00, 14, 10, 4, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    chk("R7", "arch14 unchanged", st(0, 0), 14);
    chk("R5", "arch10 last writer", st(0, 1), 36);

    // R8: return tags 4 and 7; same-cycle allocation must still stall
    apply(2'b01, 2'b01, 0, 0, 0, 20, 0, 0, 0, 0, 2'b11, 4, 7);
    chk("R8", "no same-cycle reuse", int'(rdy), 0);
    apply(2'b11, 2'b11, 20, 21, 0, 20, 20, 21, 0, 21, 2'b00, 0, 0);
    chk("R8", "rdy after return", int'(rdy), 1);
    chk("R8", "first returned", int'(dst_tag[5:0]), 4);
    chk("R8", "second returned", int'(dst_tag[11:6]), 7);
    chk("R4", "slot1 sees slot0 dst", st(1, 0), 4);
    chk("R2", "slot1 plain src", st(1, 1), 21);
    chk("R7", "stalled dst not renamed", int'(old_tag[5:0]), 20);
    // R9: renames visible next cycle
    apply(2'b01, 2'b00, 20, 21, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    chk("R9", "arch20", st(0, 0), 4);
    chk("R9", "arch21", st(0, 1), 7);

    // R8: lane 1 alone returns tag 9
    apply(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 55, 9);
    // R6: one free tag, two needed
    apply(2'b11, 2'b11, 0, 0, 0, 22, 0, 0, 0, 23, 2'b00, 0, 0);
    chk("R6", "pair short one tag", int'(rdy), 0);
    // R3: slot 1 alone takes the oldest tag
    apply(2'b10, 2'b10, 0, 0, 0, 0, 0, 0, 0, 22, 2'b00, 0, 0);
    chk("R6", "single fits", int'(rdy), 1);
    chk("R3", "slot1 oldest", int'(dst_tag[11:6]), 9);
    chk("R7", "arch22 old", int'(old_tag[11:6]), 22);
    idle();

    // R1: reset again restores identity map and pool order
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    apply(2'b01, 2'b01, 20, 22, 10, 5, 0, 0, 0, 0, 2'b00, 0, 0);
    chk("R1", "arch20 after reset", st(0, 0), 20);
    chk("R1", "arch10 after reset", st(0, 2), 10);
    chk("R1", "first pool tag", int'(dst_tag[5:0]), 32);
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule